// File: doc/BRIEF.md
# Character-Cell Horizontal Timing Generator

This block produces the horizontal timing of a character-cell display. Each character period it steps a character position counter and a 14-bit refresh memory address. From a small set of programmable registers it derives horizontal sync, a display-enable qualifier and an end-of-line event. Vertical timing is not generated here: an external `line_visible` input gates display enable, and a line counter counts completed lines.

A character period takes two clock cycles while `advance` is high. In the first window (`phase1` high) the outputs carry the state that pixel logic consumes: the refresh address and display enable of the current character, with hsync still as the previous character left it. In the second window (`phase2` high) the sync state and the address committed by that character are already visible, so sync edges can be seen before the next character begins. Software selects a register with a 5-bit index write and then writes or reads its data. A separate status read is also provided.

Top module: `crtc_htiming`

## Requirements
- R1: Horizontal sync starts on the commit of the character whose position equals register 2, and stays high for exactly W committed characters, where W is bits [3:0] of register 3 (bits [7:4] are ignored).
- R2: When register 3 bits [3:0] are zero, no sync pulse is produced: the sync started at the register 2 position is cancelled in the same character.
- R3: The refresh address increases by one on each character commit and wraps modulo 2^14 (0x3FFF is followed by 0x0000).
- R4: When the character position equals register 0, the commit returns the position to zero, loads the refresh address with the start address {register 12 bits [5:0], register 13}, raises `eol` for the following phase-2 window and adds one to `line_count`. The first line after reset starts at address 0.
- R5: `display_enable` is high exactly when the character position is below register 1 and `line_visible` is high.
- R6: `eol_address` takes the refresh address of the character whose position equals register 1 during that character's phase 1.
- R7: `rdata` returns the selected register's stored value for indices 12 to 17, and 0xFF for any other index.
- R8: `status` always reads 0xFF.
- R9: The register index is 5 bits wide, and a data write while an index above 17 is selected changes no register.
- R10: `phase1` is high in the first clock of a character and `phase2` in the second. `hsync` changes only between phase 1 and phase 2, so phase 1 shows the sync value that the previous character left.
- R11: After reset, `hsync`, `eol`, `display_enable`, `phase1` and `phase2` are low, and `refresh_address` and `line_count` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| advance | input | 1 | Character clock enable; each character uses two enabled clocks |
| line_visible | input | 1 | Current line lies in the vertical display area |
| sel_we | input | 1 | Load register index from `wdata[4:0]` |
| data_we | input | 1 | Write `wdata` to the selected register |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | Selected register readback |
| status | output | 8 | Status read value |
| hsync | output | 1 | Horizontal sync |
| display_enable | output | 1 | Character lies in the visible area |
| refresh_address | output | 14 | Refresh memory address |
| eol | output | 1 | End-of-line event, high in phase 2 of a line's last character |
| eol_address | output | 14 | Address captured where horizontal display ends |
| line_count | output | 8 | Completed lines, wrapping |
| phase1 | output | 1 | First observation window of a character |
| phase2 | output | 1 | Second observation window of a character |

## Verification
A wrong position counter shows up within one line as an address that skips or repeats, an `eol` at the wrong character, and a display-enable edge at the wrong place. A wrong sync-width count shows up as an hsync pulse whose length differs from the low nibble of register 3, visible at the end of the first pulse. Mis-decoded register indices show up at once in the readback, or a line later as a wrong start address after wrap. The bench sweeps every sync width over complete lines and compares address, enable, sync and end-of-line at both phases of every character.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
   localparam int unsigned REG_COUNT    = 18;
   localparam int unsigned IDX_HTOTAL   = 0;
   localparam int unsigned IDX_HDISP    = 1;
   localparam int unsigned IDX_HSPOS    = 2;
   localparam int unsigned IDX_HSWIDTH  = 3;
   localparam int unsigned IDX_START_HI = 12;
   localparam int unsigned IDX_START_LO = 13;
   localparam int unsigned RB_FIRST     = 12;
   localparam int unsigned RB_LAST      = 17;
endpackage

// File: rtl/crtc_regs.sv
module crtc_regs #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned SEL_W    = 5,
   parameter int unsigned NREGS    = 18,
   parameter int unsigned RB_FIRST = 12,
   parameter int unsigned RB_LAST  = 17
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          sel_we,
   input  logic                          data_we,
   input  logic [DATA_W-1:0]             wdata,
   output logic [DATA_W-1:0]             rdata,
   output logic [NREGS-1:0][DATA_W-1:0]  regs_o
);
   logic [SEL_W-1:0]             sel_q;
   logic [NREGS-1:0][DATA_W-1:0] regs_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      sel_q <= '0;
      else if (sel_we) sel_q <= wdata[SEL_W-1:0];
   end

   // one storage slot per index; unmatched indices write nothing
   for (genvar i = 0; i < NREGS; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs_q[i] <= '0;
         else if (data_we && sel_q == SEL_W'(i))
            regs_q[i] <= wdata;
      end
   end

   always_comb begin
      rdata = '1;
      for (int i = RB_FIRST; i <= RB_LAST; i++)
         if (sel_q == SEL_W'(i)) rdata = regs_q[i];
   end

   assign regs_o = regs_q;

   assert_ignored_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we && !sel_we && sel_q >= SEL_W'(NREGS)) |=> $stable(regs_q));
endmodule

// File: rtl/crtc_hsync.sv
module crtc_hsync #(
   parameter int unsigned POS_W = 8,
   parameter int unsigned WID_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit,
   input  logic [POS_W-1:0] char_pos,
   input  logic [POS_W-1:0] sync_pos,
   input  logic [WID_W-1:0] sync_width,
   output logic             hsync
);
   logic             hs_q, hs_mid, start;
   logic [WID_W-1:0] w_q, w_mid;

   assign start  = (char_pos == sync_pos);
   assign hs_mid = start | hs_q;
   assign w_mid  = start ? '0 : w_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hs_q <= 1'b0;
         w_q  <= '0;
      end else if (commit && hs_mid) begin
         if (w_mid == sync_width) begin
            hs_q <= 1'b0;
            w_q  <= w_mid;
         end else begin
            hs_q <= 1'b1;
            w_q  <= w_mid + WID_W'(1);
         end
      end
   end

   assign hsync = hs_q;

   assert_zero_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && start && sync_width == '0) |=> !hsync);
   assert_sync_ends_at_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hsync) |-> ($past(w_q) == $past(sync_width) || $past(start)));
endmodule

// File: rtl/crtc_hcount.sv
module crtc_hcount #(
   parameter int unsigned POS_W  = 8,
   parameter int unsigned ADDR_W = 14,
   parameter int unsigned LINE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ph1_go,
   input  logic              commit,
   input  logic [POS_W-1:0]  htotal,
   input  logic [POS_W-1:0]  hdisp,
   input  logic [ADDR_W-1:0] start_addr,
   output logic [POS_W-1:0]  char_pos,
   output logic [ADDR_W-1:0] ra,
   output logic              hvis,
   output logic              eol,
   output logic [ADDR_W-1:0] eol_addr,
   output logic [LINE_W-1:0] line_cnt
);
   logic [POS_W-1:0]  pos_q;
   logic [ADDR_W-1:0] ra_q, eol_addr_q;
   logic [LINE_W-1:0] line_q;
   logic              hvis_q, eol_q, at_end;

   assign at_end = (pos_q == htotal);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q      <= '0;
         ra_q       <= '0;
         line_q     <= '0;
         hvis_q     <= 1'b0;
         eol_q      <= 1'b0;
         eol_addr_q <= '0;
      end else if (ph1_go) begin
         eol_q <= 1'b0;
         if (pos_q == hdisp) begin
            hvis_q     <= 1'b0;
            eol_addr_q <= ra_q;
         end else if (pos_q == '0) begin
            hvis_q <= 1'b1;
         end
      end else if (commit) begin
         eol_q <= at_end;
         if (at_end) begin
            pos_q  <= '0;
            ra_q   <= start_addr;
            line_q <= line_q + LINE_W'(1);
         end else begin
            pos_q <= pos_q + POS_W'(1);
            ra_q  <= ra_q + ADDR_W'(1);
         end
      end
   end

   assign char_pos = pos_q;
   assign ra       = ra_q;
   assign hvis     = hvis_q;
   assign eol      = eol_q;
   assign eol_addr = eol_addr_q;
   assign line_cnt = line_q;

   assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !at_end) |=> (ra == $past(ra) + ADDR_W'(1)));
   assert_line_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && at_end) |=> (ra == $past(start_addr) && eol && char_pos == '0));
endmodule

// File: rtl/crtc_htiming.sv
module crtc_htiming
   import crtc_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 14,
   parameter int unsigned SEL_W  = 5,
   parameter int unsigned WID_W  = 4,
   parameter int unsigned LINE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   input  logic              line_visible,
   input  logic              sel_we,
   input  logic              data_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] status,
   output logic              hsync,
   output logic              display_enable,
   output logic [ADDR_W-1:0] refresh_address,
   output logic              eol,
   output logic [ADDR_W-1:0] eol_address,
   output logic [LINE_W-1:0] line_count,
   output logic              phase1,
   output logic              phase2
);
   localparam int unsigned POS_W = DATA_W;

   if (ADDR_W > 2 * DATA_W) begin : g_bad_addr
      $error("ADDR_W must fit in two registers");
   end
   if (WID_W > DATA_W) begin : g_bad_wid
      $error("WID_W must fit in one register");
   end
   if ((1 << SEL_W) < REG_COUNT) begin : g_bad_sel
      $error("SEL_W too narrow for the register count");
   end

   logic [REG_COUNT-1:0][DATA_W-1:0] regs;
   logic                             ph_q, started_q, ph1_go, commit, hvis;
   logic [POS_W-1:0]                 char_pos;
   logic [ADDR_W-1:0]                start_addr;

   crtc_regs #(
      .DATA_W(DATA_W), .SEL_W(SEL_W), .NREGS(REG_COUNT),
      .RB_FIRST(RB_FIRST), .RB_LAST(RB_LAST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .data_we(data_we),
      .wdata(wdata), .rdata(rdata), .regs_o(regs)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q      <= 1'b0;
         started_q <= 1'b0;
      end else if (advance) begin
         ph_q      <= ~ph_q;
         started_q <= 1'b1;
      end
   end

   assign ph1_go     = advance & ~ph_q;
   assign commit     = advance & ph_q;
   assign start_addr = ADDR_W'({regs[IDX_START_HI], regs[IDX_START_LO]});

   crtc_hcount #(.POS_W(POS_W), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_hcount (
      .clk(clk), .rst_n(rst_n), .ph1_go(ph1_go), .commit(commit),
      .htotal(regs[IDX_HTOTAL]), .hdisp(regs[IDX_HDISP]), .start_addr(start_addr),
      .char_pos(char_pos), .ra(refresh_address), .hvis(hvis), .eol(eol),
      .eol_addr(eol_address), .line_cnt(line_count)
   );

   crtc_hsync #(.POS_W(POS_W), .WID_W(WID_W)) u_hsync (
      .clk(clk), .rst_n(rst_n), .commit(commit), .char_pos(char_pos),
      .sync_pos(regs[IDX_HSPOS]), .sync_width(regs[IDX_HSWIDTH][WID_W-1:0]),
      .hsync(hsync)
   );

   assign display_enable = hvis & line_visible;
   assign status         = '1;
   assign phase1         = ph_q;
   assign phase2         = started_q & ~ph_q;

   assert_phase_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({phase1, phase2}));
   assert_sync_moves_into_phase2_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(hsync) |-> phase2);
   assert_enable_needs_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
      display_enable |-> line_visible);
endmodule

// File: tb/test_crtc_htiming.sv
`timescale 1ns/1ps
module test_crtc_htiming;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        advance = 1'b0;
   logic        line_visible = 1'b0;
   logic        sel_we = 1'b0;
   logic        data_we = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata, status;
   logic        hsync, display_enable, eol, phase1, phase2;
   logic [13:0] refresh_address, eol_address;
   logic [7:0]  line_count;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   crtc_htiming i_crtc_htiming (
      .clk(clk), .rst_n(rst_n), .advance(advance), .line_visible(line_visible),
      .sel_we(sel_we), .data_we(data_we), .wdata(wdata), .rdata(rdata),
      .status(status), .hsync(hsync), .display_enable(display_enable),
      .refresh_address(refresh_address), .eol(eol), .eol_address(eol_address),
      .line_count(line_count), .phase1(phase1), .phase2(phase2)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      advance = 1'b0; rst_n = 1'b0;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input int idx, input int val);
      @(negedge clk); sel_we = 1'b1; wdata = 8'(idx);
      @(negedge clk); sel_we = 1'b0; data_we = 1'b1; wdata = 8'(val);
      @(negedge clk); data_we = 1'b0;
   endtask

   task automatic rd_chk(input int idx, input int exp);
      @(negedge clk); sel_we = 1'b1; wdata = 8'(idx);
      @(negedge clk); sel_we = 1'b0; #1;
      chk("R7 readback", int'(rdata), exp);
   endtask

   // n: characters per line, v: visible count, s: sync position, w: sync width
   task automatic run_cfg(input int n, input int v, input int s, input int w,
                          input int a, input int lines);
      bit hs_prev = 1'b0;
      do_reset();
      wr(0, n - 1); wr(1, v); wr(2, s); wr(3, 8'hA0 | w);
      wr(12, (a >> 8) & 8'hFF); wr(13, a & 8'hFF);
      @(negedge clk); advance = 1'b1;
      for (int t = 0; t < n * lines; t++) begin
         int pos  = t % n;
         int line = t / n;
         int base = (line == 0) ? 0 : a;
         int ra_e = (base + pos) & 16'h3FFF;
         bit lv   = (line != 1);
         bit hs_now;
         int nxt;
         @(negedge clk); line_visible = lv; #1;
         chk("R10 phase1 window", int'(phase1), 1);
         chk("R3 address in phase1", int'(refresh_address), ra_e);
         chk("R5 display enable", int'(display_enable), int'((pos < v) && lv));
         chk("R10 hsync held from previous char", int'(hsync), int'(hs_prev));
         @(negedge clk); #1;
         hs_now = (w != 0) && (pos >= s) && (pos < s + w);
         nxt = (pos == n - 1) ? (a & 16'h3FFF) : ((ra_e + 1) & 16'h3FFF);
         chk("R10 phase2 window", int'(phase2), 1);
         chk(w == 0 ? "R2 zero width no sync" : "R1 sync window", int'(hsync), int'(hs_now));
         chk("R4 eol event", int'(eol), int'(pos == n - 1));
         chk("R3 R4 next address", int'(refresh_address), nxt);
         if (v < n && pos >= v)
            chk("R6 eol address", int'(eol_address), (base + v) & 16'h3FFF);
         hs_prev = hs_now;
      end
      @(negedge clk); advance = 1'b0; #1;
      chk("R4 line count", int'(line_count), lines & 8'hFF);
   endtask

   initial begin
      do_reset();
      #1;
      chk("R11 hsync", int'(hsync), 0);
      chk("R11 eol", int'(eol), 0);
      chk("R11 display_enable", int'(display_enable), 0);
      chk("R11 phase1", int'(phase1), 0);
      chk("R11 phase2", int'(phase2), 0);
      chk("R11 address", int'(refresh_address), 0);
      chk("R11 line count", int'(line_count), 0);
      chk("R8 status", int'(status), 8'hFF);

      // R7 R9: fill every register, then write above 17 (28 and 29 alias 12 and 13 on 4 bits)
      for (int i = 0; i < 18; i++) wr(i, (i * 13 + 5) & 8'hFF);
      wr(28, 8'h55); wr(29, 8'h66); wr(18, 8'h77); wr(31, 8'h88);
      for (int i = 0; i < 32; i++)
         rd_chk(i, (i >= 12 && i <= 17) ? ((i * 13 + 5) & 8'hFF) : 8'hFF);
      rd_chk(12, (12 * 13 + 5) & 8'hFF);  // R9 alias write left R12 untouched
      rd_chk(13, (13 * 13 + 5) & 8'hFF);  // R9 alias write left R13 untouched
      chk("R8 status after writes", int'(status), 8'hFF);

      run_cfg(10, 6, 7, 2, 16'h0123, 3);
      run_cfg(6, 4, 1, 0, 16'h3FFE, 3);
      run_cfg(20, 16, 3, 15, 16'h2000, 2);
      run_cfg(8, 0, 0, 1, 16'h3FFF, 3);
      run_cfg(5, 9, 4, 1, 16'h0040, 3);
      for (int w = 0; w < 16; w++) run_cfg(20, 10, 2, w, 16'h0100, 2);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule